// File: doc/BRIEF.md
# Memory-Mapped Chip-Select Idle Timeout

This block sits next to the chip-select driver of an external serial memory controller. In memory-mapped operation the controller keeps the device selected between accesses, so back-to-back reads need no new select and command phase. The block decides how long that select is held. Each access reported by the transfer engine restarts an idle counter. When the counter has seen the programmed number of idle cycles, the block asks the chip-select logic to let go and raises a one-cycle timeout event. When the timeout is turned off, the select is held until the mode changes or an abort arrives.

The enable for the timeout is sampled into an internal copy only while the controller reports that it is not busy. This copy is what the counter obeys. The timeout value is used live, and the counter compares against it with greater-or-equal, so lowering the value during a hold ends the hold on the next idle cycle.

Top module: `cs_idle_timeout`

## Requirements
- R1: While reset is high and on the first cycle after it, `cs_hold_o`, `release_o` and `timeout_o` are 0.
- R2: An access strobe sampled with `mode_i` = 2'b11 (memory-mapped) and abort low sets `cs_hold_o` on the following cycle. With any other mode value the strobe is ignored and `cs_hold_o` stays 0.
- R3: With the timeout in force and a value V, `cs_hold_o` drops after exactly V+1 consecutive idle cycles following the last access. In that same cycle `release_o` and `timeout_o` are both 1.
- R4: A timeout value of 0 releases the select on the first idle cycle after the access.
- R5: An access strobe during a hold restarts the idle count from zero.
- R6: With the timeout not in force, `cs_hold_o` stays 1 for any number of idle cycles in memory-mapped mode.
- R7: A mode value other than 2'b11 clears `cs_hold_o` on the next cycle. It pulses `release_o` if a hold was active, and `timeout_o` stays 0.
- R8: `abort_i` clears `cs_hold_o` on the next cycle, even when an access strobe arrives in the same cycle. It pulses `release_o` if a hold was active, and `timeout_o` stays 0.
- R9: A change of `tmo_en_i` while `busy_i` is 1 has no effect. The change is taken on the first clock edge with `busy_i` at 0.
- R10: `release_o` and `timeout_o` are single-cycle pulses. `timeout_o` is never 1 without `release_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Functional mode; 2'b11 is memory-mapped |
| tmo_en_i | input | 1 | Timeout enable request |
| busy_i | input | 1 | Controller busy; blocks enable updates |
| tmo_val_i | input | CNT_W | Idle cycles allowed beyond the first |
| access_i | input | 1 | One-cycle strobe per memory-mapped access |
| abort_i | input | 1 | Abort; drops the select at once |
| cs_hold_o | output | 1 | Chip-select held active |
| release_o | output | 1 | One-cycle request to release chip-select |
| timeout_o | output | 1 | One-cycle flag: release caused by idle timeout |

## Verification
The assertions assume that `mode_i`, `abort_i` and `access_i` are clean synchronous levels that are free of X after reset. They also assume that a release can only follow a hold that was set by an access. The bench changes every input on the falling clock edge and only after reset has been applied. It moves `tmo_en_i` under `busy_i` only in the sequence dedicated to that rule. The timeout value is changed only between holds, so each sweep point sees one fixed value.

// File: rtl/cs_tmo_pkg.sv
package cs_tmo_pkg;

  typedef enum logic [1:0] {
    MODE_IND_WR = 2'b00,
    MODE_IND_RD = 2'b01,
    MODE_POLL   = 2'b10,
    MODE_MMAP   = 2'b11
  } fmode_e;

  typedef struct packed {
    logic rel;
    logic tmo;
  } cs_evt_t;

endpackage

// File: rtl/cs_tmo_cfg.sv
module cs_tmo_cfg (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  input  logic tmo_en_i,
  output logic en_q
);
  always_ff @(posedge clk) begin
    if (rst)          en_q <= 1'b0;
    else if (!busy_i) en_q <= tmo_en_i;
  end
endmodule

// File: rtl/cs_tmo_counter.sv
module cs_tmo_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q >= limit);
endmodule

// File: rtl/cs_tmo_ctrl.sv
module cs_tmo_ctrl
  import cs_tmo_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    mmap,
  input  logic    abort_i,
  input  logic    access_i,
  input  logic    en,
  input  logic    hit,
  output logic    hold_q,
  output cs_evt_t evt_q,
  output logic    cnt_clr,
  output logic    cnt_inc
);
  logic stop, expire;

  always_comb begin
    stop    = !mmap || abort_i;
    expire  = hold_q && en && !access_i && hit && !stop;
    cnt_clr = stop || access_i || !hold_q || !en || expire;
    cnt_inc = hold_q && en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      evt_q  <= '0;
    end else begin
      evt_q <= '0;
      if (stop) begin
        hold_q    <= 1'b0;
        evt_q.rel <= hold_q;
      end else if (access_i) begin
        hold_q <= 1'b1;
      end else if (expire) begin
        hold_q    <= 1'b0;
        evt_q.rel <= 1'b1;
        evt_q.tmo <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cs_idle_timeout.sv
module cs_idle_timeout
  import cs_tmo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             tmo_en_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] tmo_val_i,
  input  logic             access_i,
  input  logic             abort_i,
  output logic             cs_hold_o,
  output logic             release_o,
  output logic             timeout_o
);
  logic             en_q, hit, cnt_clr, cnt_inc, hold_q, mmap;
  logic [CNT_W-1:0] cnt_q;
  cs_evt_t          evt_q;

  assign mmap = (fmode_e'(mode_i) == MODE_MMAP);

  cs_tmo_cfg u_cfg (
    .clk(clk), .rst(rst), .busy_i(busy_i), .tmo_en_i(tmo_en_i), .en_q(en_q)
  );

  cs_tmo_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .limit(tmo_val_i), .cnt_q(cnt_q), .hit(hit)
  );

  cs_tmo_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mmap(mmap), .abort_i(abort_i), .access_i(access_i),
    .en(en_q), .hit(hit), .hold_q(hold_q), .evt_q(evt_q),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc)
  );

  assign cs_hold_o = hold_q;
  assign release_o = evt_q.rel;
  assign timeout_o = evt_q.tmo;
endmodule

// File: rtl/cs_idle_timeout_chk.sv
module cs_idle_timeout_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_i,
  input logic             access_i,
  input logic             abort_i,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] tmo_val_i,
  input logic             cs_hold_o,
  input logic             release_o,
  input logic             timeout_o
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!cs_hold_o && !release_o && !timeout_o));

  p_mmap_access_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b11 && access_i && !abort_i) |=> cs_hold_o);

  p_tmo_needs_rel_r10: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> release_o);

  p_rel_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    release_o |=> !release_o);

  p_rel_after_hold_r3: assert property (@(posedge clk) disable iff (rst)
    release_o |-> (!cs_hold_o && $past(cs_hold_o)));

  p_leave_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'b11) |=> (!cs_hold_o && !timeout_o));

  p_abort_drop_r8: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!cs_hold_o && !timeout_o));

  p_disabled_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (cs_hold_o && !en_q && mode_i == 2'b11 && !abort_i) |=> cs_hold_o);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    ($stable(tmo_val_i) && cs_hold_o) |-> (cnt_q <= tmo_val_i));
endmodule

bind cs_idle_timeout cs_idle_timeout_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .access_i(access_i), .abort_i(abort_i),
  .en_q(en_q), .cnt_q(cnt_q), .tmo_val_i(tmo_val_i),
  .cs_hold_o(cs_hold_o), .release_o(release_o), .timeout_o(timeout_o)
);

// File: tb/tb_cs_idle_timeout.sv
module tb_cs_idle_timeout;
  localparam int W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'b11;
  logic tmo_en = 1'b0, busy = 1'b0, access = 1'b0, abort_r = 1'b0;
  logic [W-1:0] tval = '0;
  logic hold, rel, tmo;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  cs_idle_timeout #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .mode_i(mode), .tmo_en_i(tmo_en), .busy_i(busy),
    .tmo_val_i(tval), .access_i(access), .abort_i(abort_r),
    .cs_hold_o(hold), .release_o(rel), .timeout_o(tmo)
  );

  task automatic chk(input string req, input logic [2:0] exp);
    n_chk++;
    if ({hold, rel, tmo} !== exp) begin
      n_fail++;
      $display("FAIL %s: {hold,rel,tmo} actual %b expected %b at %0t", req, {hold, rel, tmo}, exp, $time);
    end
  endtask

  // one-cycle access strobe; returns at the negedge after the capturing edge
  task automatic strobe();
    access = 1'b1;
    @(negedge clk);
    access = 1'b0;
  endtask

  task automatic idle_run(input int v, input string req);
    for (int i = 1; i <= v; i++) begin
      @(negedge clk);
      chk(req, 3'b100);
    end
    @(negedge clk);
    chk(req, 3'b011);
    @(negedge clk);
    chk("R10", 3'b000);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", 3'b000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", 3'b000);

    // R2: strobe outside memory-mapped mode ignored
    for (int m = 0; m < 3; m++) begin
      mode = m[1:0];
      strobe();
      chk("R2", 3'b000);
    end
    mode = 2'b11;

    // R6: timeout disabled, hold survives long idle
    strobe();
    chk("R2", 3'b100);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (i % 50 == 49) chk("R6", 3'b100);
    end

    // R7: leaving mode drops hold without timeout flag
    mode = 2'b01;
    @(negedge clk);
    chk("R7", 3'b010);
    mode = 2'b11;
    @(negedge clk);
    chk("R7", 3'b000);

    // enable timeout (not busy)
    tmo_en = 1'b1;
    @(negedge clk);

    // R3/R4: sweep of timeout values
    for (int v = 0; v <= 12; v++) begin
      tval = W'(v);
      strobe();
      chk("R3", 3'b100);
      idle_run(v, (v == 0) ? "R4" : "R3");
    end
    tval = W'(200);
    strobe();
    idle_run(200, "R3");

    // R5: access restarts count
    tval = W'(5);
    strobe();
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R5", 3'b100);
    strobe();
    chk("R5", 3'b100);
    idle_run(5, "R5");

    // R8: abort with simultaneous access
    tval = W'(20);
    strobe();
    @(negedge clk);
    abort_r = 1'b1; access = 1'b1;
    @(negedge clk);
    chk("R8", 3'b010);
    access = 1'b0;
    @(negedge clk);
    chk("R8", 3'b000);
    abort_r = 1'b0;

    // R9: enable change ignored while busy
    busy = 1'b1; tmo_en = 1'b0; tval = W'(2);
    @(negedge clk);
    strobe();
    idle_run(2, "R9");
    busy = 1'b0;
    @(negedge clk);
    strobe();
    for (int i = 0; i < 40; i++) @(negedge clk);
    chk("R9", 3'b100);
    abort_r = 1'b1;
    @(negedge clk);
    chk("R8", 3'b010);
    abort_r = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule